// File: doc/BRIEF.md
# Edge-Driven Phase Step Accumulator

This block is the digital control part of a clock phase aligner. It turns rising edges on an asynchronous step-request input into a phase index that an analog delay line elsewhere consumes. Each step moves the index by one position. An asynchronous direction level, sampled together with the step, selects whether the index goes up (the output clock moves earlier) or down (the output clock moves later). The index wraps modulo a resolution, and the resolution depends on the selected operating ratio.

Both control inputs pass through synchronizers into the system clock. A step is the 0-to-1 transition of the synchronized request. Each applied update raises a one-cycle strobe, and a flag beside the strobe carries the direction. On purpose, the block drops one request in every `SKIP_PERIOD`. Software may clear the index synchronously, which gives a calibration routine a known start position. Any change of the ratio setting clears both the index and the request counter. When the aligner is switched off, incoming edges have no effect.

Top module: `pstep_accum`

## Requirements
- R1: After reset `phase_idx` is 0 and `upd_stb` is 0.
- R2: Each 0-to-1 transition of `step_req` gives at most one update, however long the input stays high. The new index appears after the third rising clock edge that follows the input change.
- R3: If `step_dir` is 1 at the step, the index increases by one and `upd_adv` is 1. If it is 0, the index decreases by one and `upd_adv` is 0.
- R4: Increasing from modulus-1 gives 0, and decreasing from 0 gives modulus-1.
- R5: The modulus is `BASE_RES` when `div_mode` is 0, whatever `ratio_sel` holds. When `div_mode` is 1, the modulus is 8×`BASE_RES` for `ratio_sel` 00, 16×`BASE_RES` for 01, and 32×`BASE_RES` for 10 and 11.
- R6: Requests are counted from reset or from the last ratio change. Every `SKIP_PERIOD`-th request is dropped: the index stays the same and no strobe is raised.
- R7: `upd_stb` is high for exactly one cycle for each applied update and is low at all other times.
- R8: A one-cycle pulse on `idx_clear` makes the index read 0 on the next cycle. The request counter keeps its count.
- R9: Any change of `div_mode` or `ratio_sel` sets the index to 0 on the next cycle and restarts the request count.
- R10: While `aligner_on` is 0, step edges change neither the index nor the request count, and they raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_req | input | 1 | Asynchronous step request; rising edges count |
| step_dir | input | 1 | Asynchronous direction level: 1 up, 0 down |
| aligner_on | input | 1 | Enables step processing |
| div_mode | input | 1 | 0 multiply family, 1 divide family |
| ratio_sel | input | 2 | Ratio select within the family |
| idx_clear | input | 1 | Synchronous clear of the phase index |
| phase_idx | output | IDX_W | Current phase index |
| upd_stb | output | 1 | One-cycle strobe per applied update |
| upd_adv | output | 1 | Direction of the update shown by the strobe |

## Verification
The bench builds the block with `BASE_RES` = 12 and `SKIP_PERIOD` = 8. These values give moduli of 12, 96, 192 and 384. A handful of steps then reaches the multiply-mode wrap, one downward step from 0 checks the top value of every divide setting, and the dropped request comes round every eighth edge. With these values the dropped request can be seen landing during a downward run, and after a bypass interval the bench can show whether the request counter moved or kept its count.

// File: rtl/pstep_pkg.sv
package pstep_pkg;

  typedef struct packed {
    logic       div_mode;
    logic [1:0] sel;
  } ratio_cfg_t;

  // Steps per output period for a given ratio setting.
  function automatic int unsigned res_of(ratio_cfg_t cfg, int unsigned base);
    if (!cfg.div_mode) return base;
    case (cfg.sel)
      2'b00:   return base * 8;
      2'b01:   return base * 16;
      default: return base * 32;
    endcase
  endfunction

  // One step with wrap: up from mod-1 goes to 0, down from 0 goes to mod-1.
  function automatic int unsigned step_index(int unsigned idx, int unsigned modulus, logic up);
    if (up) return (idx + 1 == modulus) ? 0 : idx + 1;
    return (idx == 0) ? modulus - 1 : idx - 1;
  endfunction

endpackage

// File: rtl/pstep_edge_sync.sv
module pstep_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], async_in};
  end

  assign sync_out = sh[STAGES-1];
  assign rise     = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/pstep_skip_gate.sv
module pstep_skip_gate #(
  parameter int SKIP_PERIOD = 32,
  localparam int CNT_W = $clog2(SKIP_PERIOD)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic restart,
  output logic apply,
  output logic skip_hit
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SKIP_PERIOD - 1);
  logic [CNT_W-1:0] cnt_q;

  assign skip_hit = req && !restart && (cnt_q == LAST);
  assign apply    = req && !restart && (cnt_q != LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (req)     cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/pstep_phase_index.sv
module pstep_phase_index #(
  parameter int IDX_W = 14,
  parameter int MOD_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             apply,
  input  logic             up,
  input  logic             clear,
  input  logic [MOD_W-1:0] modulus,
  output logic [IDX_W-1:0] idx,
  output logic             stb,
  output logic             stb_up
);
  logic [IDX_W-1:0] idx_next;

  assign idx_next = IDX_W'(pstep_pkg::step_index(int'(unsigned'(idx)),
                                                 int'(unsigned'(modulus)), up));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx    <= '0;
      stb    <= 1'b0;
      stb_up <= 1'b0;
    end else begin
      stb    <= apply && !clear;
      stb_up <= up;
      if (clear)      idx <= '0;
      else if (apply) idx <= idx_next;
    end
  end
endmodule

// File: rtl/pstep_accum.sv
module pstep_accum #(
  parameter int BASE_RES    = 384,
  parameter int SKIP_PERIOD = 32,
  parameter int SYNC_STAGES = 2,
  localparam int MAX_RES = BASE_RES * 32,
  localparam int MOD_W   = $clog2(MAX_RES + 1),
  localparam int IDX_W   = $clog2(MAX_RES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_req,
  input  logic             step_dir,
  input  logic             aligner_on,
  input  logic             div_mode,
  input  logic [1:0]       ratio_sel,
  input  logic             idx_clear,
  output logic [IDX_W-1:0] phase_idx,
  output logic             upd_stb,
  output logic             upd_adv
);
  import pstep_pkg::*;

  logic       step_sync, step_rise;
  logic       dir_sync, dir_rise;
  logic       req, apply, skip_hit;
  logic       cfg_chg, clear_any;
  ratio_cfg_t cfg_in, cfg_q;
  logic [MOD_W-1:0] cur_mod;

  pstep_edge_sync #(.STAGES(SYNC_STAGES)) u_step_sync (
    .clk(clk), .rst_n(rst_n), .async_in(step_req),
    .sync_out(step_sync), .rise(step_rise));

  pstep_edge_sync #(.STAGES(SYNC_STAGES)) u_dir_sync (
    .clk(clk), .rst_n(rst_n), .async_in(step_dir),
    .sync_out(dir_sync), .rise(dir_rise));

  assign cfg_in  = '{div_mode: div_mode, sel: ratio_sel};
  assign cfg_chg = (cfg_in != cfg_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_in;
  end

  assign cur_mod   = MOD_W'(res_of(cfg_q, BASE_RES));
  assign req       = step_rise && aligner_on;
  assign clear_any = idx_clear || cfg_chg;

  pstep_skip_gate #(.SKIP_PERIOD(SKIP_PERIOD)) u_skip (
    .clk(clk), .rst_n(rst_n), .req(req), .restart(cfg_chg),
    .apply(apply), .skip_hit(skip_hit));

  pstep_phase_index #(.IDX_W(IDX_W), .MOD_W(MOD_W)) u_idx (
    .clk(clk), .rst_n(rst_n), .apply(apply), .up(dir_sync),
    .clear(clear_any), .modulus(cur_mod),
    .idx(phase_idx), .stb(upd_stb), .stb_up(upd_adv));

endmodule

// File: rtl/pstep_checker.sv
module pstep_checker #(
  parameter int IDX_W = 14,
  parameter int MOD_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             aligner_on,
  input logic [IDX_W-1:0] phase_idx,
  input logic             upd_stb,
  input logic             upd_adv,
  input logic [MOD_W-1:0] cur_mod,
  input logic             skip_hit,
  input logic             clear_any,
  input logic             cfg_chg
);
  logic [MOD_W-1:0] idx_w;
  assign idx_w = MOD_W'(phase_idx);

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_w < cur_mod); // R5

  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb && upd_adv && ($past(idx_w) + MOD_W'(1) != $past(cur_mod))
    |-> idx_w == $past(idx_w) + MOD_W'(1)); // R3

  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb && !upd_adv && ($past(idx_w) != '0)
    |-> idx_w == $past(idx_w) - MOD_W'(1)); // R3

  AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb && !upd_adv && ($past(idx_w) == '0)
    |-> idx_w == cur_mod - MOD_W'(1)); // R4

  AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb && upd_adv && ($past(idx_w) + MOD_W'(1) == $past(cur_mod))
    |-> idx_w == '0); // R4

  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    skip_hit |=> !upd_stb); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb && !$past(clear_any) |-> $stable(phase_idx)); // R7

  AST_CFG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> phase_idx == '0); // R9

  AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !aligner_on |=> !upd_stb); // R10
endmodule

bind pstep_accum pstep_checker #(.IDX_W(IDX_W), .MOD_W(MOD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .aligner_on(aligner_on), .phase_idx(phase_idx),
  .upd_stb(upd_stb), .upd_adv(upd_adv), .cur_mod(cur_mod),
  .skip_hit(skip_hit), .clear_any(clear_any), .cfg_chg(cfg_chg));

// File: tb/sim_pstep_accum.sv
`timescale 1ns/1ps
module sim_pstep_accum;
  localparam int BASE  = 12;
  localparam int SKIP  = 8;
  localparam int IDX_W = $clog2(BASE * 32);

  logic clk = 0, rst_n = 0;
  logic step_req = 0, step_dir = 0, aligner_on = 1, div_mode = 0, idx_clear = 0;
  logic [1:0] ratio_sel = 2'b00;
  logic [IDX_W-1:0] phase_idx;
  logic upd_stb, upd_adv;

  int checks = 0, errors = 0;
  int stb_n = 0, adv_n = 0;
  int exp_idx = 0, req_cnt = 0, modulus = BASE;

  always #5 clk = ~clk;

  pstep_accum #(.BASE_RES(BASE), .SKIP_PERIOD(SKIP)) u0 (
    .clk(clk), .rst_n(rst_n), .step_req(step_req), .step_dir(step_dir),
    .aligner_on(aligner_on), .div_mode(div_mode), .ratio_sel(ratio_sel),
    .idx_clear(idx_clear), .phase_idx(phase_idx), .upd_stb(upd_stb),
    .upd_adv(upd_adv));

  always @(posedge clk) if (upd_stb) begin
    stb_n++;
    if (upd_adv) adv_n++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int mod_for(input bit dv, input bit [1:0] s);
    if (!dv) return BASE;
    if (s == 2'b00) return BASE * 8;
    if (s == 2'b01) return BASE * 16;
    return BASE * 32;
  endfunction

  // One request; the direction line completes a full cycle per step.
  task automatic do_step(input bit d, input int hold, input string tag);
    int s0 = stb_n, a0 = adv_n;
    bit applies = 0;
    if (aligner_on) begin
      applies = (req_cnt != SKIP - 1);
      req_cnt = (req_cnt + 1) % SKIP;
      if (applies) exp_idx = (((exp_idx + (d ? 1 : -1)) % modulus) + modulus) % modulus;
    end
    @(negedge clk) step_dir = ~d;
    repeat (2) @(negedge clk);
    step_dir = d;
    @(negedge clk) step_req = 1;
    repeat (hold) @(negedge clk);
    step_req = 0;
    repeat (4) @(negedge clk);
    chk(tag, int'(phase_idx), exp_idx);
    chk({tag, " strobe count R7"}, stb_n - s0, int'(applies));
    if (applies) chk("R3 direction flag", adv_n - a0, int'(d));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 index after reset", int'(phase_idx), 0);
    chk("R1 strobe after reset", int'(upd_stb), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_up_run();
    for (int i = 0; i < 5; i++) do_step(1'b1, 4, "R3 up step");
  endtask

  task automatic t_down_wrap_skip();
    // requests 6..12: the 8th is dropped, then the index wraps below 0
    for (int i = 0; i < 7; i++) do_step(1'b0, 4, "R4 R6 down run");
    chk("R4 wrap to top", int'(phase_idx), BASE - 1);
  endtask

  task automatic t_up_wrap();
    do_step(1'b1, 4, "R4 up wrap");
    chk("R4 up wrap to 0", int'(phase_idx), 0);
  endtask

  task automatic t_long_hold();
    do_step(1'b1, 25, "R2 long high request");
  endtask

  task automatic t_clear();
    @(negedge clk) idx_clear = 1;
    @(negedge clk) idx_clear = 0;
    exp_idx = 0;
    chk("R8 clear", int'(phase_idx), 0);
    do_step(1'b1, 4, "R8 counter kept after clear");
  endtask

  task automatic t_bypass();
    aligner_on = 0;
    for (int i = 0; i < 3; i++) do_step(1'b1, 4, "R10 bypass ignored");
    aligner_on = 1;
    for (int i = 0; i < SKIP; i++) do_step(1'b1, 4, "R10 count frozen");
  endtask

  task automatic set_ratio(input bit dv, input bit [1:0] s, input string tag);
    @(negedge clk) begin div_mode = dv; ratio_sel = s; end
    repeat (2) @(negedge clk);
    exp_idx = 0; req_cnt = 0; modulus = mod_for(dv, s);
    chk(tag, int'(phase_idx), 0);
  endtask

  task automatic t_ratios();
    do_step(1'b1, 4, "R3 before ratio change");
    set_ratio(1'b0, 2'b01, "R9 multiply ratio change clears");
    do_step(1'b0, 4, "R5 multiply modulus");
    set_ratio(1'b1, 2'b00, "R9 divide /2 clears");
    do_step(1'b0, 4, "R5 divide /2 modulus");
    set_ratio(1'b1, 2'b01, "R9 divide /3 clears");
    do_step(1'b0, 4, "R5 divide /3 modulus");
    set_ratio(1'b1, 2'b10, "R9 divide /4 clears");
    do_step(1'b0, 4, "R5 divide /4 modulus");
    set_ratio(1'b1, 2'b11, "R9 code 11 clears");
    do_step(1'b0, 4, "R5 code 11 modulus");
    for (int i = 0; i < 14; i++) do_step(1'b1, 4, "R6 skip in divide mode");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_up_run();
    t_down_wrap_skip();
    t_up_wrap();
    t_long_hold();
    t_clear();
    t_bypass();
    t_ratios();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule